// File: doc/BRIEF.md
# Compressed Load/Store Trap Instruction Transformer

This combinational unit builds the transformed-instruction value that trap handling records when a load or store faults. It takes the raw trapped instruction word and a register-width selector. Compressed loads and stores from quadrants 0 and 2 are expanded into the matching 32-bit base encoding. Bit 1 of that result is then cleared, so the handler can tell that the original instruction was 16 bits wide. A full-width instruction goes through unchanged. Every other compressed encoding gives zero.

In the expanded word, the base-register field does not hold a register. It holds the address offset between the faulting address and the original address. Misaligned accesses never trap in this design, so that offset is always zero. The unit sits between the trap-cause logic and the trap CSR write port. It has no state.

Top module: `tinst_xform`

## Requirements
- R1: When insn_i[1:0] is 2'b11, tinst_o equals insn_i bit for bit.
- R2: Quadrant 1 (insn_i[1:0]=2'b01) gives zero. So do quadrant 0 function code 0 and quadrant 2 function codes 0 and 4 (function code = insn_i[15:13]).
- R3: Quadrant 0 loads (codes 1, 2, 3) expand to an I-type load. The destination is 8+insn_i[4:2]. The immediate sits in bits 31:20. The word offset is {insn_i[5],insn_i[12:10],insn_i[6]}<<2 and the doubleword offset is {insn_i[6:5],insn_i[12:10]}<<3.
- R4: Quadrant 0 stores (codes 5, 6, 7) expand to an S-type store with rs2 = 8+insn_i[4:2]. The low 5 immediate bits go to bits 11:7 and the upper 7 bits go to bits 31:25. The offsets are the same as in R3.
- R5: Quadrant 2 loads (codes 1, 2, 3) take the destination from insn_i[11:7]. The word offset is {insn_i[3:2],insn_i[12],insn_i[6:4]}<<2 and the doubleword offset is {insn_i[4:2],insn_i[12],insn_i[6:5]}<<3.
- R6: Quadrant 2 stores (codes 5, 6, 7) take rs2 from insn_i[6:2]. The word offset is {insn_i[8:7],insn_i[12:9]}<<2 and the doubleword offset is {insn_i[9:7],insn_i[12:10]}<<3.
- R7: xlen_sel_i encodes the register width: 0 means 32, 1 means 64, and 2 or 3 means 128.
  - Codes 1 and 5 become FLD and FSD, except at width 128, where the output is all zeros.
  - Code 2 becomes LW and code 6 becomes SW.
  - Codes 3 and 7 become FLW and FSW at width 32, and LD and SD at the other widths.
- R8: The opcode and funct3 of every expansion are standard, before bit 1 is cleared.
  - Opcodes: integer load 0000011, integer store 0100011, FP load 0000111, FP store 0100111.
  - funct3: 010 for word accesses and 011 for doubleword accesses.
- R9: For every compressed expansion, bits 19:15 (the address offset) are zero and bit 1 is zero.
- R10: For compressed inputs, insn_i[31:16] has no effect on tinst_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| insn_i | input | 32 | Raw trapped instruction word |
| xlen_sel_i | input | 2 | Register width selector (0:32, 1:64, 2/3:128) |
| tinst_o | output | 32 | Transformed instruction value |

## Verification
The embedded assertions check these on every input change:
- full-width pass-through;
- zero output for quadrant 1;
- zero offset field and cleared bit 1 for any compressed result;
- a legal opcode for every non-zero compressed result.

The exact register and immediate placement, the width-dependent choice between FP and integer doubleword forms, and the insensitivity to the upper half are shown only by the bench. It compares each random and directed stimulus against its own reference encoder.

// File: rtl/tix_pkg.sv
package tix_pkg;
  localparam int INSN_W = 32;
  localparam int HALF_W = 16;
  localparam int IMM_W  = 12;
  localparam int REG_W  = 5;
  localparam int F3_W   = 3;

  localparam logic [1:0] QUAD0 = 2'b00;
  localparam logic [1:0] QUAD1 = 2'b01;
  localparam logic [1:0] QUAD2 = 2'b10;
  localparam logic [1:0] WIDE  = 2'b11;

  localparam logic [1:0] XW32 = 2'd0;

  // Decoded memory operation class
  typedef struct packed {
    logic valid;
    logic store;
    logic fp;
    logic dword;
    logic sp_rel;
  } xop_t;
endpackage

// File: rtl/tix_op_select.sv
module tix_op_select
  import tix_pkg::*;
(
  input  logic [1:0] quad_i,
  input  logic [2:0] func_i,
  input  logic [1:0] xlen_i,
  output xop_t       op_o
);
  logic wide128;
  logic narrow32;

  assign wide128  = xlen_i[1];
  assign narrow32 = (xlen_i == XW32);

  always_comb begin
    op_o = '0;
    if (quad_i == QUAD0 || quad_i == QUAD2) begin
      op_o.sp_rel = (quad_i == QUAD2);
      op_o.store  = func_i[2];
      unique case (func_i[1:0])
        2'd1: begin
          op_o.valid = !wide128;
          op_o.fp    = 1'b1;
          op_o.dword = 1'b1;
        end
        2'd2: begin
          op_o.valid = 1'b1;
        end
        2'd3: begin
          op_o.valid = 1'b1;
          op_o.fp    = narrow32;
          op_o.dword = !narrow32;
        end
        default: op_o.valid = 1'b0;
      endcase
      if (!op_o.valid) op_o = '0;
    end
  end
endmodule

// File: rtl/tix_field_extract.sv
module tix_field_extract
  import tix_pkg::*;
(
  input  logic [HALF_W-1:0] half_i,
  input  xop_t              op_i,
  output logic [REG_W-1:0]  reg_o,
  output logic [IMM_W-1:0]  imm_o
);
  logic [IMM_W-1:0] q0_w, q0_d, q2_lw, q2_ld, q2_sw, q2_sd;

  assign q0_w  = IMM_W'({half_i[5], half_i[12:10], half_i[6], 2'b00});
  assign q0_d  = IMM_W'({half_i[6:5], half_i[12:10], 3'b000});
  assign q2_lw = IMM_W'({half_i[3:2], half_i[12], half_i[6:4], 2'b00});
  assign q2_ld = IMM_W'({half_i[4:2], half_i[12], half_i[6:5], 3'b000});
  assign q2_sw = IMM_W'({half_i[8:7], half_i[12:9], 2'b00});
  assign q2_sd = IMM_W'({half_i[9:7], half_i[12:10], 3'b000});

  always_comb begin
    if (!op_i.sp_rel) begin
      reg_o = {2'b01, half_i[4:2]};
      imm_o = op_i.dword ? q0_d : q0_w;
    end else if (op_i.store) begin
      reg_o = half_i[6:2];
      imm_o = op_i.dword ? q2_sd : q2_sw;
    end else begin
      reg_o = half_i[11:7];
      imm_o = op_i.dword ? q2_ld : q2_lw;
    end
  end
endmodule

// File: rtl/tinst_xform.sv
module tinst_xform
  import tix_pkg::*;
(
  input  logic [31:0] insn_i,
  input  logic [1:0]  xlen_sel_i,
  output logic [31:0] tinst_o
);
  localparam int OFS_LO = 15;
  localparam int OFS_HI = OFS_LO + REG_W - 1;

  xop_t             op;
  logic [REG_W-1:0] rsel;
  logic [IMM_W-1:0] imm;
  logic [F3_W-1:0]  funct3;
  logic [6:0]       opcode;
  logic [INSN_W-1:0] expanded;

  tix_op_select u_sel (
    .quad_i (insn_i[1:0]),
    .func_i (insn_i[15:13]),
    .xlen_i (xlen_sel_i),
    .op_o   (op)
  );

  tix_field_extract u_fld (
    .half_i (insn_i[HALF_W-1:0]),
    .op_i   (op),
    .reg_o  (rsel),
    .imm_o  (imm)
  );

  assign funct3 = {2'b01, op.dword};
  assign opcode = {1'b0, op.store, 2'b00, op.fp, 2'b11};

  always_comb begin
    if (op.store)
      expanded = {imm[11:5], rsel, {REG_W{1'b0}}, funct3, imm[4:0], opcode};
    else
      expanded = {imm, {REG_W{1'b0}}, funct3, rsel, opcode};
    if (insn_i[1:0] == WIDE)
      tinst_o = insn_i;
    else if (op.valid)
      tinst_o = expanded & ~32'h2;
    else
      tinst_o = '0;
  end

  always_comb begin
    if (insn_i[1:0] == WIDE)
      p_passthru_r1: assert (tinst_o == insn_i);
    if (insn_i[1:0] == QUAD1)
      p_quad1_zero_r2: assert (tinst_o == '0);
    if (insn_i[1:0] != WIDE) begin
      p_offset_zero_r9: assert (tinst_o[OFS_HI:OFS_LO] == '0 && !tinst_o[1]);
      if (tinst_o != '0)
        p_opcode_legal_r8: assert (tinst_o[6:0] == 7'b0000001 ||
                                   tinst_o[6:0] == 7'b0100001 ||
                                   tinst_o[6:0] == 7'b0000101 ||
                                   tinst_o[6:0] == 7'b0100101);
    end
  end
endmodule

// File: tb/tinst_xform_test.sv
module tinst_xform_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] insn;
  logic [1:0]  xsel;
  logic [31:0] tinst;
  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  tinst_xform uut (.insn_i(insn), .xlen_sel_i(xsel), .tinst_o(tinst));

  // Reference: independent per-instruction encoder
  function automatic logic [31:0] ref_xf(logic [31:0] w, logic [1:0] xs);
    logic [4:0] rd, rs2;
    logic [11:0] off;
    logic [6:0] opc;
    logic [2:0] f3;
    logic ld, ok;
    bit is32, is128;
    is32 = (xs == 2'd0);
    is128 = (xs >= 2'd2);
    ok = 1; ld = 0; opc = 0; f3 = 0; rd = 0; rs2 = 0; off = 0;
    if (w[1:0] == 2'b11) return w;
    case ({w[1:0], w[15:13]})
      5'b00_001: begin ok = !is128; ld = 1; opc = 7'h07; f3 = 3; end
      5'b00_010: begin ld = 1; opc = 7'h03; f3 = 2; end
      5'b00_011: begin ld = 1; opc = is32 ? 7'h07 : 7'h03; f3 = is32 ? 2 : 3; end
      5'b00_101: begin ok = !is128; opc = 7'h27; f3 = 3; end
      5'b00_110: begin opc = 7'h23; f3 = 2; end
      5'b00_111: begin opc = is32 ? 7'h27 : 7'h23; f3 = is32 ? 2 : 3; end
      5'b10_001: begin ok = !is128; ld = 1; opc = 7'h07; f3 = 3; end
      5'b10_010: begin ld = 1; opc = 7'h03; f3 = 2; end
      5'b10_011: begin ld = 1; opc = is32 ? 7'h07 : 7'h03; f3 = is32 ? 2 : 3; end
      5'b10_101: begin ok = !is128; opc = 7'h27; f3 = 3; end
      5'b10_110: begin opc = 7'h23; f3 = 2; end
      5'b10_111: begin opc = is32 ? 7'h27 : 7'h23; f3 = is32 ? 2 : 3; end
      default: ok = 0;
    endcase
    if (!ok) return 32'h0;
    if (w[1:0] == 2'b00) begin
      rd = 5'd8 + 5'(w[4:2]); rs2 = rd;
      if (f3 == 3) off = (12'(w[12:10]) << 3) | (12'(w[6:5]) << 6);
      else off = (12'(w[12:10]) << 3) | (12'(w[6]) << 2) | (12'(w[5]) << 6);
    end else begin
      rd = w[11:7]; rs2 = w[6:2];
      if (ld) begin
        if (f3 == 3) off = (12'(w[6:5]) << 3) | (12'(w[12]) << 5) | (12'(w[4:2]) << 6);
        else off = (12'(w[6:4]) << 2) | (12'(w[12]) << 5) | (12'(w[3:2]) << 6);
      end else begin
        if (f3 == 3) off = (12'(w[12:10]) << 3) | (12'(w[9:7]) << 6);
        else off = (12'(w[12:9]) << 2) | (12'(w[8:7]) << 6);
      end
    end
    opc[1] = 1'b0;
    if (ld) return {off, 5'd0, f3, rd, opc};
    return {off[11:5], rs2, 5'd0, f3, off[4:0], opc};
  endfunction

  function automatic string tag_of(logic [31:0] w, logic [1:0] xs);
    if (w[1:0] == 2'b11) return "R1";
    if (w[1:0] == 2'b01 || w[14:13] == 2'b00) return "R2";
    if ((w[14:13] == 2'b01 || w[14:13] == 2'b11) && xs != 0 && w[15:13] != 3'b110)
      return "R7";
    if (w[1:0] == 2'b00) return w[15] ? "R4" : "R3";
    return w[15] ? "R6" : "R5";
  endfunction

  task automatic check(string tag, logic [31:0] w, logic [1:0] xs, logic [31:0] exp);
    insn = w; xsel = xs;
    @(negedge clk);
    n_run++;
    if (tinst !== exp) begin
      n_fail++;
      $display("FAIL %s insn=%h xlen=%0d actual=%h expected=%h", tag, w, xs, tinst, exp);
    end
  endtask

  initial begin
    #1500000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240524));
    insn = '0; xsel = '0;
    repeat (2) @(negedge clk);
    // Idle/zero input: quadrant 0 code 0 gives zero
    check("R2", 32'h0, 2'd0, 32'h0);
    // Directed: c.lw x9, 4(x8) -> lw with offset 4, rd 9
    check("R3", 32'h0000_4044, 2'd0, 32'h0040_2481);
    check("R1", 32'h00A1_2083, 2'd1, 32'h00A1_2083);
    check("R2", 32'hFFFF_FFFD, 2'd2, 32'h0);
    check("R7", 32'h0000_2000, 2'd2, 32'h0);  // q0 code1 at 128 -> zero
    check("R7", 32'h0000_A000, 2'd3, 32'h0);  // q0 code5 at 128 -> zero
    check("R8", 32'h0000_6000, 2'd0, ref_xf(32'h0000_6000, 2'd0));
    check("R9", 32'h0000_FFFE, 2'd1, ref_xf(32'h0000_FFFE, 2'd1));
    // Upper half ignored for compressed input
    for (int i = 0; i < 200; i++) begin
      logic [15:0] h;
      logic [1:0] xs;
      h = 16'($urandom); xs = 2'($urandom);
      if (h[1:0] == 2'b11) h[1] = 1'b0;
      check("R10", {16'($urandom), h}, xs, ref_xf({16'h0, h}, xs));
    end
    // Random mix over every quadrant, code and width
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] w;
      logic [1:0] xs;
      w = $urandom; xs = 2'($urandom);
      if (i % 4 != 0) w[1] = 1'b0;
      check(tag_of(w, xs), w, xs, ref_xf(w, xs));
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule